// File: doc/BRIEF.md
# Short Pulse Catcher

This block catches asynchronous pulses that may be much narrower than one period of the system clock. It also turns each caught pulse into a single strobe in the system clock domain. The pulse input is never sampled. Instead, it drives the clock pin of a capture flop whose next value is always the inverse of its present value. Because of this, every rising edge of the input leaves a lasting change of level, however short the pulse was.

That level crosses into the system clock domain through a chain of `SYNC_STAGES` flops. A two-state detector then records the last level it has accepted. Its states are `SEEN_LOW` and `SEEN_HIGH`, and its two transitions are named RISE_SEEN (`SEEN_LOW` to `SEEN_HIGH` when the synchronized level is 1) and FALL_SEEN (`SEEN_HIGH` to `SEEN_LOW` when it is 0). The strobe is high in any cycle where the synchronized level differs from the level held by the state. This is an XOR change detector, written as a state machine.

Input pulses must be at least `SYNC_STAGES + 1` system clock cycles apart, which is three cycles at the default. Pulses that come closer together than that may be merged into one strobe or lost. The active-low reset is asynchronous and clears every stored bit, including the capture flop.

Top module: `pulse_catcher`

## Requirements
- R1: Each rising edge of `pulse_in` is caught, including pulses narrower than half a system clock period, whatever their phase relative to `clk`.
- R2: Each caught edge produces exactly one strobe on `strobe_o`, and that strobe lasts exactly one `clk` cycle.
- R3: The strobe is high during the cycle that follows the `SYNC_STAGES`-th rising `clk` edge after the input's rising edge. At the default of 2, that is after the second edge.
- R4: When `rst_n` is 0, all state clears at once, without waiting for a `clk` edge, and `strobe_o` is 0. This includes a strobe that was already high.
- R5: After `rst_n` rises, `strobe_o` stays 0 until the first rising edge of `pulse_in`. Input edges that occur while `rst_n` is 0 produce no strobe.
- R6: Pulses spaced exactly `SYNC_STAGES + 1` clock cycles apart each produce their own strobe, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_in | input | 1 | Asynchronous pulse input; its rising edge clocks the capture flop |
| strobe_o | output | 1 | One-cycle strobe for each caught pulse, synchronous to `clk` |

## Verification
The bench builds the block with `SYNC_STAGES = 2`, so the exact two-edge latency of R3 is checked against every strobe. With that setting, the minimum spacing of three cycles can be driven back to back. Pulses between 1 and 9 ns wide are placed at random offsets within a 20 ns period. This covers pulses that begin and end between two clock edges, which no sampling scheme could see. Reset is applied while a strobe is high, and again while pulses arrive, to cover both sides of R4 and R5.

// File: rtl/pulse_catch_pkg.sv
package pulse_catch_pkg;
    // Default synchronizer depth; two is the minimum for a metastability guard.
    localparam int DEFAULT_SYNC_STAGES = 2;

    // Last synchronized level accepted by the change detector.
    typedef enum logic {
        SEEN_LOW  = 1'b0,
        SEEN_HIGH = 1'b1
    } seen_state_t;
endpackage

// File: rtl/pc_toggle_capture.sv
// Capture flop clocked by the asynchronous pulse itself; flips on every rising edge.
module pc_toggle_capture (
    input  logic pulse_in,
    input  logic rst_n,
    output logic level_o
);
    logic level_q;
    logic level_d;

    always_comb begin
        level_d = level_q;
        level_d = ~level_q;
    end

    always_ff @(posedge pulse_in or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_d;
        end
    end

    assign level_o = level_q;
endmodule

// File: rtl/pc_level_sync.sv
// Multi-flop synchronizer bringing the captured level into the clk domain.
module pc_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic level_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic [LAST:0] chain_d;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("pc_level_sync: STAGES must be at least 2");
        end
    endgenerate

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = level_i;
        for (int i = 1; i <= LAST; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign level_o = chain_q[LAST];
endmodule

// File: rtl/pc_change_detect.sv
// Two-state change detector: remembers the last accepted level, strobes on a difference.
module pc_change_detect
    import pulse_catch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic strobe_o,
    output logic seen_o
);
    seen_state_t state_q;
    seen_state_t state_d;

    // Next-state process: hold by default, move on RISE_SEEN / FALL_SEEN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEEN_LOW:  if (level_i)  state_d = SEEN_HIGH; // RISE_SEEN
            SEEN_HIGH: if (!level_i) state_d = SEEN_LOW;  // FALL_SEEN
            default:   state_d = SEEN_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEEN_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: strobe while the incoming level disagrees with the state.
    always_comb begin
        strobe_o = 1'b0;
        unique case (state_q)
            SEEN_LOW:  strobe_o = level_i;
            SEEN_HIGH: strobe_o = ~level_i;
            default:   strobe_o = 1'b0;
        endcase
    end

    assign seen_o = (state_q == SEEN_HIGH);
endmodule

// File: rtl/pulse_catcher.sv
module pulse_catcher
    import pulse_catch_pkg::*;
#(
    parameter int SYNC_STAGES = DEFAULT_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic strobe_o
);
    logic captured_level;
    logic sync_level;
    logic seen_level;

    pc_toggle_capture u_capture (
        .pulse_in (pulse_in),
        .rst_n    (rst_n),
        .level_o  (captured_level)
    );

    pc_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (captured_level),
        .level_o (sync_level)
    );

    pc_change_detect u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (sync_level),
        .strobe_o (strobe_o),
        .seen_o   (seen_level)
    );
endmodule

// File: rtl/pulse_catch_checker.sv
module pulse_catch_checker (
    input logic clk,
    input logic rst_n,
    input logic strobe,
    input logic sync_level,
    input logic seen_level
);
    // R2: a strobe never lasts beyond one cycle (inputs respect the spacing limit, R6)
    assert_strobe_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R2: every change of the synchronized level is reported as a strobe
    assert_change_gives_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_level != $past(sync_level)) |-> strobe);

    // R5: with no change of level there is no strobe
    assert_quiet_without_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_level == $past(sync_level)) |-> !strobe);

    // R4: while reset is held, the output and all stored levels are zero
    assert_reset_clears_R4: assert property (@(posedge clk)
        !rst_n |-> (!strobe && !sync_level && !seen_level));

    // R2: after a strobe, the detector has taken up the level it reported
    assert_seen_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (seen_level == $past(sync_level)));
endmodule

bind pulse_catcher pulse_catch_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe_o),
    .sync_level (sync_level),
    .seen_level (seen_level)
);

// File: tb/tb_pulse_catcher.sv
`timescale 1ns/1ps
module tb_pulse_catcher;
    localparam int SYNC = 2;
    localparam int MAX_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic pulse_in = 1'b0;
    logic strobe_o;

    int checks = 0;
    int fails = 0;
    int pcnt = 0;
    int strobes_seen = 0;
    bit done = 1'b0;
    int exp_q[$];

    pulse_catcher #(.SYNC_STAGES(SYNC)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (pulse_in),
        .strobe_o (strobe_o)
    );

    always #10 clk = ~clk; // 50 MHz

    always @(posedge clk) pcnt <= pcnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: waits gap cycles, fires a short pulse at a chosen phase, pushes the expectation.
    task automatic send_pulse(input int gap, input int delay_ns, input int width_ns);
        repeat (gap) @(posedge clk);
        #(delay_ns);
        exp_q.push_back(pcnt);
        pulse_in = 1'b1;
        #(width_ns);
        pulse_in = 1'b0;
    endtask

    // Monitor: pops one expectation per strobe and checks its latency.
    always @(negedge clk) begin
        if (rst_n) begin
            if (strobe_o) begin
                strobes_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 spurious strobe", 1, 0);
                end else begin
                    int stamp;
                    stamp = exp_q.pop_front();
                    check(pcnt - stamp == SYNC, "R3 strobe latency (R1 caught)",
                          pcnt - stamp, SYNC);
                end
            end else if (exp_q.size() != 0 && pcnt - exp_q[0] > SYNC + 2) begin
                check(1'b0, "R1 pulse missed", pcnt - exp_q[0], SYNC);
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        done = 1'b1;
        $finish;
    endtask

    initial begin
        #(MAX_CYCLES * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", pcnt, MAX_CYCLES);
            finish_run();
        end
    end

    initial begin
        int base;
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        check(strobe_o == 1'b0, "R4 reset state", strobe_o, 0);
        // R5: edges during reset leave no trace
        pulse_in = 1'b1; #2; pulse_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        base = strobes_seen;
        repeat (8) @(posedge clk);
        #5;
        check(strobes_seen == base, "R5 quiet after reset release", strobes_seen - base, 0);

        // R1/R2/R3: narrow pulses at random phases and spacings
        for (int i = 0; i < 40; i++) begin
            send_pulse($urandom_range(6, 3), $urandom_range(12, 1), $urandom_range(9, 1));
        end
        repeat (6) @(posedge clk);
        #5;
        check(exp_q.size() == 0, "R2 all pulses matched", exp_q.size(), 0);

        // R6: minimum spacing burst, each pulse at the narrowest width
        base = strobes_seen;
        for (int i = 0; i < 10; i++) begin
            send_pulse(SYNC + 1, 2 + (i % 8), 1);
        end
        repeat (6) @(posedge clk);
        #5;
        check(strobes_seen - base == 10, "R6 one strobe per spaced pulse", strobes_seen - base, 10);

        // R4: asynchronous reset clears a strobe that is high
        @(posedge clk);
        #3;
        pulse_in = 1'b1; #2; pulse_in = 1'b0;
        repeat (SYNC) @(posedge clk);
        #2;
        check(strobe_o == 1'b1, "R3 strobe high after sync edges", strobe_o, 1);
        rst_n = 1'b0;
        #1;
        check(strobe_o == 1'b0, "R4 async clear without clock", strobe_o, 0);
        repeat (2) @(posedge clk);
        #3;
        rst_n = 1'b1;
        base = strobes_seen;
        repeat (6) @(posedge clk);
        #5;
        check(strobes_seen == base, "R5 no strobe after second release", strobes_seen - base, 0);

        // R1: the first edge after release is still caught
        send_pulse(1, 7, 3);
        repeat (6) @(posedge clk);
        #5;
        check(exp_q.size() == 0, "R1 first edge after reset caught", exp_q.size(), 0);
        finish_run();
    end
endmodule